// File: doc/BRIEF.md
# Output-Queued Wormhole Switch with Flit-Level Go-Back-N

This block is a P-by-P packet switch for an on-chip network. Packets travel as flits in wormhole fashion and carry their route with them (source routing). A head flit names its output port in the low bits of its route field. The switch shifts those bits out, so the next switch finds its own selector in the same position. Each output owns a small FIFO. When a head flit wins an output, that output stays tied to the winning input until the packet's tail flit has passed.

The switch never stalls a sender. A flit that cannot go forward is discarded and answered with a NACK. Every accepted flit is answered with an ACK. There are four reasons to discard a flit:
- its output is tied to another packet;
- its output FIFO is full;
- it lost arbitration;
- its link CRC check failed.

After a discard, the input also refuses every later non-head flit until a head flit shows up again. This is go-back-N at flit level: the sender rewinds to the head of the packet and sends it again.

The input side has no ready signal. An input presents a flit with `in_valid`, and its ACK or NACK comes back two cycles later. The output side is valid/ready. A flit is taken from an output when `out_valid` and `out_ready` are both high in the same cycle. While `out_ready` is low, the flit on offer stays fixed.

Top module: `gbn_switch`

## Requirements
- R1: A flit presented on an input in cycle t is first visible on its output in cycle t+2 when that output FIFO was empty. The flit layout has four fields.
  - Bits [FW-1:FW-2] hold the kind: 2'b01 head, 2'b00 body, 2'b10 tail, 2'b11 single (head and tail in one flit).
  - Bits [FW-3:DW] hold the route. Its low log2(P) bits select the output.
  - Bits [DW-1:0] hold the payload.
  - A head or single flit leaves with its route shifted right by log2(P) and zero filled. Body and tail flits leave unchanged.
- R2: Every flit presented on input i in cycle t gets exactly one pulse on `ack[i]` or `nack[i]` in cycle t+2. No pulse appears otherwise.
- R3: Each output FIFO keeps the order in which flits entered it. While `out_ready` is low, `out_valid` and `out_flit` hold their values. A flit arriving at a FIFO that already holds QDEPTH flits is NACKed and not stored.
- R4: Several heads may request the same free output in one cycle. With round robin (the default), the grant goes to the first requester at or after the pointer. The pointer then moves to one past the winner, and it moves only on a grant. With fixed priority, the lowest input index wins.
- R5: After a non-single head wins an output, heads from other inputs are NACKed on that output. This lasts until the owner's tail is accepted or the owner presents a new head.
- R6: After input i has a flit NACKed, every later body or tail flit on input i is NACKed until a head or single flit arrives on it.
- R7: A flit presented with `in_crc_ok` low is NACKed and produces nothing on any output.
- R8: With go-back-N senders retrying after each NACK, every packet appears on its output exactly once, with its flits in order and never interleaved with another packet's flits.
- R9: After reset, all outputs are invalid, no ACK or NACK is pulsed, and no output is tied to an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | P | Flit present on each input |
| in_flit | input | P*FW | Input flits, input i at [i*FW +: FW] |
| in_crc_ok | input | P | Link CRC result for each presented flit |
| ack | output | P | Flit accepted, two cycles after presentation |
| nack | output | P | Flit discarded, two cycles after presentation |
| out_valid | output | P | Output FIFO holds a flit |
| out_ready | input | P | Downstream takes the offered flit |
| out_flit | output | P*FW | Output flits, output o at [o*FW +: FW] |

## Verification
Two kinds of internal error show up quickly at the ports.

A wrong ownership record or a stale discard flag changes which input gets ACK and which gets NACK. The wrong response appears two cycles after the affected flit. Under retrying senders, it then shows as a duplicated, missing or interleaved packet on the output within one packet time.

A wrong round-robin pointer changes the winner of the next collision on that output. It shows in that collision's ACK/NACK pair.

FIFO pointer or count errors show as reordered or lost payloads. They also show as a missing NACK when the FIFO is exactly full.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  // flit kind codes, two top bits of a flit
  localparam logic [1:0] KIND_BODY   = 2'b00;
  localparam logic [1:0] KIND_HEAD   = 2'b01;
  localparam logic [1:0] KIND_TAIL   = 2'b10;
  localparam logic [1:0] KIND_SINGLE = 2'b11;
endpackage

// File: rtl/gbn_arbiter.sv
module gbn_arbiter #(
  parameter int P  = 4,
  parameter bit RR = 1'b1,
  localparam int LOGP = $clog2(P)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] req,
  input  logic         en,
  output logic [P-1:0] gnt
);
  generate
    if (RR) begin : g_rr
      logic [LOGP-1:0] ptr, nxt;
      always_comb begin
        logic found;
        int   idx;
        gnt   = '0;
        nxt   = ptr;
        found = 1'b0;
        for (int k = 0; k < P; k++) begin
          idx = (int'(ptr) + k) % P;
          if (!found && en && req[idx]) begin
            gnt[idx] = 1'b1;
            nxt      = LOGP'((idx + 1) % P);
            found    = 1'b1;
          end
        end
      end
      always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (en && (|req)) ptr <= nxt;
      end
    end else begin : g_fixed
      always_comb begin
        logic found;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < P; k++) begin
          if (!found && en && req[k]) begin
            gnt[k] = 1'b1;
            found  = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gbn_oqueue.sv
module gbn_oqueue #(
  parameter int W     = 26,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign valid   = (cnt != '0);
  assign dout    = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= din;
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/gbn_switch.sv
module gbn_switch #(
  parameter int P           = 4,
  parameter int DW          = 16,
  parameter int RB          = 8,
  parameter int QDEPTH      = 4,
  parameter bit ROUND_ROBIN = 1'b1,
  localparam int FW   = 2 + RB + DW,
  localparam int LOGP = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [P-1:0]  in_valid,
  input  logic [P*FW-1:0] in_flit,
  input  logic [P-1:0]  in_crc_ok,
  output logic [P-1:0]  ack,
  output logic [P-1:0]  nack,
  output logic [P-1:0]  out_valid,
  input  logic [P-1:0]  out_ready,
  output logic [P*FW-1:0] out_flit
);
  // stage register: one cycle of the two-cycle path
  logic [P-1:0]  sv, sc;
  logic [FW-1:0] sf [P];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv <= '0;
      sc <= '0;
    end else begin
      sv <= in_valid;
      sc <= in_crc_ok;
    end
    for (int i = 0; i < P; i++) sf[i] <= in_flit[i*FW +: FW];
  end

  logic [P-1:0]    is_head, is_tail;
  logic [LOGP-1:0] dest [P];
  for (genvar i = 0; i < P; i++) begin : g_dec
    assign is_head[i] = sf[i][FW-2];
    assign is_tail[i] = sf[i][FW-1];
    assign dest[i]    = sf[i][DW +: LOGP];
  end

  // path ownership per output, discard mode per input
  logic [P-1:0]    lock_v, dmode;
  logic [LOGP-1:0] lock_who [P];
  logic [P-1:0]    own_v;
  logic [LOGP-1:0] own_p [P];
  always_comb begin
    for (int i = 0; i < P; i++) begin
      own_v[i] = 1'b0;
      own_p[i] = '0;
      for (int o = 0; o < P; o++)
        if (lock_v[o] && lock_who[o] == LOGP'(i)) begin
          own_v[i] = 1'b1;
          own_p[i] = LOGP'(o);
        end
    end
  end

  logic [P-1:0] release_o, busy, full;
  logic [P-1:0] req [P];
  logic [P-1:0] gnt [P];
  for (genvar o = 0; o < P; o++) begin : g_out
    assign release_o[o] = lock_v[o] && sv[lock_who[o]] && is_head[lock_who[o]];
    assign busy[o]      = lock_v[o] && !release_o[o];
    for (genvar i = 0; i < P; i++) begin : g_req
      assign req[o][i] = sv[i] && sc[i] && is_head[i] && (dest[i] == LOGP'(o)) && !busy[o];
    end
    gbn_arbiter #(.P(P), .RR(ROUND_ROBIN)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req[o]), .en(!full[o]), .gnt(gnt[o])
    );
  end

  logic [P-1:0] cont, acc_head, accept, drop;
  always_comb begin
    for (int i = 0; i < P; i++) begin
      cont[i]     = sv[i] && sc[i] && !is_head[i] && !dmode[i] && own_v[i] && !full[own_p[i]];
      acc_head[i] = 1'b0;
      for (int o = 0; o < P; o++) acc_head[i] = acc_head[i] | gnt[o][i];
    end
    accept = acc_head | cont;
    drop   = sv & ~accept;
  end

  // queue write selection, route rewrite on heads
  logic [P-1:0]    push, win_tail, tail_pass;
  logic [LOGP-1:0] win_idx [P];
  logic [FW-1:0]   push_flit [P];
  always_comb begin
    for (int o = 0; o < P; o++) begin
      push[o]      = 1'b0;
      win_tail[o]  = 1'b0;
      tail_pass[o] = 1'b0;
      win_idx[o]   = '0;
      push_flit[o] = '0;
      for (int i = 0; i < P; i++) begin
        if (gnt[o][i]) begin
          push[o]      = 1'b1;
          win_tail[o]  = is_tail[i];
          win_idx[o]   = LOGP'(i);
          push_flit[o] = {sf[i][FW-1:FW-2], sf[i][FW-3:DW] >> LOGP, sf[i][DW-1:0]};
        end
        if (cont[i] && own_p[i] == LOGP'(o)) begin
          push[o]      = 1'b1;
          tail_pass[o] = is_tail[i];
          push_flit[o] = sf[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_v <= '0;
      dmode  <= '0;
      ack    <= '0;
      nack   <= '0;
      for (int o = 0; o < P; o++) lock_who[o] <= '0;
    end else begin
      ack  <= sv & accept;
      nack <= drop;
      for (int o = 0; o < P; o++) begin
        if (|gnt[o]) begin
          lock_v[o]   <= !win_tail[o];
          lock_who[o] <= win_idx[o];
        end else if (release_o[o] || tail_pass[o]) begin
          lock_v[o] <= 1'b0;
        end
      end
      for (int i = 0; i < P; i++)
        if (sv[i]) dmode[i] <= drop[i];
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_q
    gbn_oqueue #(.W(FW), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push[o]), .din(push_flit[o]), .full(full[o]),
      .ready(out_ready[o]), .valid(out_valid[o]), .dout(out_flit[o*FW +: FW])
    );
  end
endmodule

// File: rtl/gbn_switch_chk.sv
module gbn_switch_chk #(
  parameter int P  = 4,
  parameter int FW = 26
) (
  input logic          clk,
  input logic          rst_n,
  input logic [P-1:0]  in_valid,
  input logic [P*FW-1:0] in_flit,
  input logic [P-1:0]  in_crc_ok,
  input logic [P-1:0]  ack,
  input logic [P-1:0]  nack,
  input logic [P-1:0]  out_valid,
  input logic [P-1:0]  out_ready,
  input logic [P*FW-1:0] out_flit
);
  logic [1:0] age;
  logic warm;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age >= 2'd2);

  for (genvar i = 0; i < P; i++) begin : g_in
    // R2: one response per presented flit, two cycles later
    p_one_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> ((ack[i] | nack[i]) == $past(in_valid[i], 2)) && !(ack[i] && nack[i]));
    // R7: CRC failure is always refused
    p_crc_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(in_valid[i] && !in_crc_ok[i], 2)) |-> nack[i]);
    // R6: a refused flit followed by a non-head flit refuses that one too
    p_discard_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && nack[i] && $past(in_valid[i] && !in_flit[i*FW + FW - 2])) |=> nack[i]);
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    // R3: offered flit held while not taken
    p_hold_offer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o*FW +: FW])));
    // R1: an output only starts offering in the cycle some flit is acknowledged
    p_enter_with_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[o]) |-> (ack != '0));
  end
endmodule

bind gbn_switch gbn_switch_chk #(.P(P), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
  .in_crc_ok(in_crc_ok), .ack(ack), .nack(nack), .out_valid(out_valid),
  .out_ready(out_ready), .out_flit(out_flit)
);

// File: tb/tb_gbn_switch.sv
module tb_gbn_switch;
  localparam int P = 4, DW = 16, RB = 8, QD = 4;
  localparam int FW = 2 + RB + DW;
  localparam logic [1:0] K_BODY = 2'b00, K_HEAD = 2'b01, K_TAIL = 2'b10, K_ONE = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [P-1:0] in_valid = '0, in_crc_ok = '0, out_ready = '1;
  logic [P*FW-1:0] in_flit = '0;
  logic [P-1:0] ack, nack, out_valid;
  logic [P*FW-1:0] out_flit;

  int n_chk = 0, n_fail = 0;

  gbn_switch #(.P(P), .DW(DW), .RB(RB), .QDEPTH(QD), .ROUND_ROBIN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit), .in_crc_ok(in_crc_ok),
    .ack(ack), .nack(nack), .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit)
  );

  always #10ns clk = ~clk;

  function automatic logic [FW-1:0] mk(logic [1:0] k, logic [RB-1:0] r, logic [DW-1:0] p);
    return {k, r, p};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int i, logic [FW-1:0] f, bit crc);
    in_valid[i] = 1'b1;
    in_flit[i*FW +: FW] = f;
    in_crc_ok[i] = crc;
  endtask

  task automatic idle();
    in_valid = '0;
    in_crc_ok = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] oflit(int o);
    return out_flit[o*FW +: FW];
  endfunction

  task automatic t_reset();
    chk(out_valid == '0, "R9 out_valid", 64'(out_valid), 0);
    chk(ack == '0 && nack == '0, "R9 responses", 64'({ack, nack}), 0);
  endtask

  task automatic t_latency();
    put(0, mk(K_HEAD, 8'hB6, 16'h1111), 1); step();
    chk(out_valid[2] == 1'b0, "R1 not early", 64'(out_valid[2]), 0);
    idle(); put(0, mk(K_BODY, 8'hB6, 16'h2222), 1); step();
    chk(out_valid[2] && oflit(2) == mk(K_HEAD, 8'h2D, 16'h1111), "R1 head rewritten", 64'(oflit(2)), 64'(mk(K_HEAD, 8'h2D, 16'h1111)));
    chk(ack[0] && !nack[0], "R2 head acked", 64'({ack[0], nack[0]}), 2);
    idle(); put(0, mk(K_TAIL, 8'h55, 16'h3333), 1); step();
    chk(out_valid[2] && oflit(2) == mk(K_BODY, 8'hB6, 16'h2222), "R1 body unchanged", 64'(oflit(2)), 64'(mk(K_BODY, 8'hB6, 16'h2222)));
    idle(); step();
    chk(out_valid[2] && oflit(2) == mk(K_TAIL, 8'h55, 16'h3333), "R1 tail unchanged", 64'(oflit(2)), 64'(mk(K_TAIL, 8'h55, 16'h3333)));
    step();
    chk(out_valid[2] == 1'b0, "R1 drained", 64'(out_valid[2]), 0);
  endtask

  task automatic t_round_robin();
    // output 0 pointer starts at 0: input 1 wins, then pointer 2: input 3 wins
    put(1, mk(K_ONE, 8'h00, 16'h0101), 1); put(3, mk(K_ONE, 8'h00, 16'h0301), 1); step();
    idle(); step();
    chk(ack[1] && nack[3], "R4 first winner input1", 64'({ack[1], nack[3]}), 3);
    chk(out_valid[0] && oflit(0)[DW-1:0] == 16'h0101, "R4 first payload", 64'(oflit(0)[DW-1:0]), 16'h0101);
    put(1, mk(K_ONE, 8'h00, 16'h0102), 1); put(3, mk(K_ONE, 8'h00, 16'h0302), 1); step();
    idle(); step();
    chk(ack[3] && nack[1], "R4 rotated winner input3", 64'({ack[3], nack[1]}), 3);
    chk(out_valid[0] && oflit(0)[DW-1:0] == 16'h0302, "R4 second payload", 64'(oflit(0)[DW-1:0]), 16'h0302);
    step();
  endtask

  task automatic t_hold();
    put(0, mk(K_HEAD, 8'h01, 16'hA000), 1); step();
    idle(); put(2, mk(K_ONE, 8'h01, 16'hB000), 1); step();
    idle(); step();
    chk(nack[2], "R5 other head refused while held", 64'(nack[2]), 1);
    put(0, mk(K_TAIL, 8'h00, 16'hA001), 1); step();
    idle(); step();
    chk(out_valid[1] && oflit(1)[DW-1:0] == 16'hA001 && ack[0], "R5 owner tail passes", 64'(oflit(1)[DW-1:0]), 16'hA001);
    put(2, mk(K_ONE, 8'h01, 16'hB001), 1); step();
    idle(); step();
    chk(ack[2] && out_valid[1] && oflit(1)[DW-1:0] == 16'hB001, "R5 released after tail", 64'(oflit(1)[DW-1:0]), 16'hB001);
    step();
  endtask

  task automatic t_go_back();
    // output 3 pointer at 0: input 1 beats input 2
    put(1, mk(K_HEAD, 8'h03, 16'hC000), 1); put(2, mk(K_HEAD, 8'h03, 16'hD000), 1); step();
    idle(); put(1, mk(K_TAIL, 8'h00, 16'hC001), 1); put(2, mk(K_BODY, 8'h00, 16'hD001), 1); step();
    idle();
    chk(nack[2] && ack[1], "R6 head lost", 64'({nack[2], ack[1]}), 3);
    step();
    chk(nack[2], "R6 body after drop refused", 64'(nack[2]), 1);
    put(2, mk(K_ONE, 8'h03, 16'hD002), 1); step();
    idle(); step();
    chk(ack[2], "R6 head clears discard", 64'(ack[2]), 1);
    step(); step();
  endtask

  task automatic t_crc();
    put(3, mk(K_ONE, 8'h00, 16'hEEEE), 0); step();
    idle(); step();
    chk(nack[3] && !ack[3], "R7 crc refused", 64'({ack[3], nack[3]}), 1);
    chk(out_valid == '0, "R7 nothing emitted", 64'(out_valid), 0);
    step();
  endtask

  task automatic t_full();
    out_ready[3] = 1'b0;
    for (int k = 0; k < 7; k++) begin
      if (k >= 2) chk(ack[0] == (k - 2 < QD) && nack[0] == (k - 2 >= QD), "R3 full refuses fifth", 64'({ack[0], nack[0]}), (k - 2 < QD) ? 2 : 1);
      idle();
      if (k < 5) put(0, mk(K_ONE, 8'h03, 16'(k)), 1);
      step();
    end
    chk(out_valid[3] && oflit(3)[DW-1:0] == 16'd0, "R3 held offer", 64'(oflit(3)[DW-1:0]), 0);
    out_ready[3] = 1'b1;
    for (int j = 0; j < QD; j++) begin
      chk(out_valid[3] && oflit(3)[DW-1:0] == 16'(j), "R3 fifo order", 64'(oflit(3)[DW-1:0]), 64'(j));
      step();
    end
    chk(out_valid[3] == 1'b0, "R3 empty after drain", 64'(out_valid[3]), 0);
  endtask

  task automatic t_senders();
    int cur[3], ep[3], got[3];
    bit done[3];
    bit hv[3][4];
    int hi[3][4], he[3][4];
    int open_src = -1, nxt = 0;
    for (int s = 0; s < 3; s++) begin
      cur[s] = 0; ep[s] = 0; got[s] = 0; done[s] = 0;
      for (int h = 0; h < 4; h++) begin hv[s][h] = 0; hi[s][h] = 0; he[s][h] = 0; end
    end
    for (int t = 0; t < 300; t++) begin
      if (out_valid[2]) begin
        logic [FW-1:0] f = oflit(2);
        int src = int'(f[15:8]);
        int sq = int'(f[7:0]);
        if (f[FW-2]) begin
          chk(open_src == -1 && sq == 0, "R8 head starts clean", 64'(open_src), 64'(-1));
          open_src = src; nxt = 1;
        end else begin
          chk(src == open_src && sq == nxt, "R8 no interleave", 64'(src), 64'(open_src));
          nxt++;
        end
        if (f[FW-1]) begin
          if (src >= 0 && src < 3) got[src]++;
          open_src = -1;
        end
      end
      for (int s = 0; s < 3; s++) begin
        int slot = (t + 2) % 4;
        if (hv[s][slot]) begin
          if (ack[s] == nack[s]) chk(0, "R2 exactly one response", 64'({ack[s], nack[s]}), 1);
          if (he[s][slot] == ep[s]) begin
            if (nack[s]) begin ep[s]++; cur[s] = 0; end
            else if (hi[s][slot] == 2) done[s] = 1;
          end
        end
        hv[s][t % 4] = 0;
        in_valid[s] = 1'b0;
        if (!done[s] && cur[s] < 3) begin
          logic [1:0] k = (cur[s] == 0) ? K_HEAD : (cur[s] == 2) ? K_TAIL : K_BODY;
          put(s, mk(k, 8'h02, {8'(s), 8'(cur[s])}), 1);
          hv[s][t % 4] = 1; hi[s][t % 4] = cur[s]; he[s][t % 4] = ep[s];
          cur[s]++;
        end
      end
      step();
    end
    idle();
    for (int s = 0; s < 3; s++) begin
      chk(done[s], "R8 sender finished", 64'(done[s]), 1);
      chk(got[s] == 1, "R8 delivered once", 64'(got[s]), 1);
    end
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_latency();
    t_round_robin();
    t_hold();
    t_go_back();
    t_crc();
    t_full();
    t_senders();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule